// File: doc/BRIEF.md
# HyperBus Command Register Front End

This block is the software-facing register layer that sits in front of a HyperBus memory transaction engine. A 32-bit word-addressed bus port reaches seven registers: command, configuration, address, write data, read data, interrupt enable and interrupt status. Software loads an address and, for writes, a data word. It then writes an opcode into the command register. The block checks the opcode and hands one operation to the engine as a single-cycle start pulse.

While the operation runs, the command field reads back the opcode that is in flight, which tells software the interface is busy. When the engine signals completion, the field drops back to zero. Read data is captured for read-type opcodes, and a done flag is raised that can drive an interrupt line. Physical bus sequencing and byte ordering belong to the engine and its neighbours. The configuration word is passed to them unchanged.

Top module: `hbus_cmd_front`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is 0 and `eng_start_o` is 0.
- R2: Registers are word aligned, with the byte offset carried in `bus_addr_i`:
  - 0x00 is the command register. A read returns the live command field in bits [3:0].
  - 0x04 is the configuration register, full 32 bits, read and write.
  - 0x08 is the byte address register, full 32 bits, read and write.
  - 0x0C is the write data register, full 32 bits, read and write.
  - 0x10 is the read data register. It is read only; writes to it have no effect.
  - 0x14 is the interrupt enable register, bit 0 only.
  - 0x18 is the interrupt status register, bit 0 only.
  - Any other offset, including one with nonzero bits [1:0], reads 0 and ignores writes.
- R3: A command write of a valid opcode while idle makes `eng_start_o` high for exactly the next cycle. In that cycle `eng_op_o` carries the opcode, and `eng_addr_o` and `eng_wdata_o` carry the address and write data registers.
- R4: From the cycle after launch until the cycle after `eng_done_i` is seen, the command field reads the active opcode. After that it reads 0000.
- R5: Only these opcodes are valid:
  - 0001: reset.
  - 0010: register read.
  - 0101: wake.
  - 0111: register write.
  - 1000 and 1001: one-word and two-word read.
  - 1100 to 1111: writes of 1 to 4 bytes.
  A command write of any other code is ignored: there is no start pulse and the command field stays 0000.
- R6: A command write while busy is ignored: there is no start pulse and the command field keeps the active opcode.
- R7: The status bit clears at launch and is set on the cycle after completion. Writing 1 to bit 0 clears it, and writing 0 has no effect. Completion in the same cycle as a clearing write leaves the bit set.
- R8: `irq_o` equals the status bit AND the enable bit.
- R9: On completion of opcode 0010, 1000 or 1001, the read data register takes `eng_rdata_i`. Completion of any other opcode leaves it unchanged.
- R10: `eng_done_i` while idle has no effect on the command field, the status bit or the read data register.
- R11: `eng_cfg_o` always equals the configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the offset |
| eng_start_o | output | 1 | One-cycle operation launch |
| eng_op_o | output | 4 | Opcode of the operation |
| eng_addr_o | output | 32 | Byte address for the engine |
| eng_wdata_o | output | 32 | Write data for the engine |
| eng_cfg_o | output | 32 | Configuration word for the engine |
| eng_done_i | input | 1 | Operation completion pulse |
| eng_rdata_i | input | 32 | Read data accompanying completion |
| irq_o | output | 1 | Done interrupt |

## Verification
A corrupted busy flag shows up in one of two ways on the next readout of offset 0x00: the opcode stays there after completion, or it reads zero mid-operation. The same fault either suppresses the start of the next command or lets a stray one through, which the per-clock comparison of `eng_start_o` catches one cycle after the write. A status or enable error reaches `irq_o` within a cycle of completion. A wrong capture decision shows on the next read of offset 0x10, so each read opcode is followed by such a read, and so is a write opcode with distinct engine data.

// File: rtl/hbus_front_pkg.sv
`timescale 1ns/1ps
package hbus_front_pkg;
  localparam int unsigned OP_W = 4;
  localparam int unsigned NREG = 7;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 4'b0000, OP_RST  = 4'b0001, OP_RREG = 4'b0010,
    OP_WAKE = 4'b0101, OP_WREG = 4'b0111, OP_RD1  = 4'b1000,
    OP_RD2  = 4'b1001, OP_WB1  = 4'b1100, OP_WB2  = 4'b1101,
    OP_WB3  = 4'b1110, OP_WB4  = 4'b1111
  } op_e;

  localparam int unsigned IDX_CMD = 0;
  localparam int unsigned IDX_CFG = 1;
  localparam int unsigned IDX_ADR = 2;
  localparam int unsigned IDX_WDT = 3;
  localparam int unsigned IDX_RDT = 4;
  localparam int unsigned IDX_IEN = 5;
  localparam int unsigned IDX_STS = 6;

  function automatic logic op_is_valid(logic [OP_W-1:0] c);
    case (c)
      OP_RST, OP_RREG, OP_WAKE, OP_WREG, OP_RD1, OP_RD2,
      OP_WB1, OP_WB2, OP_WB3, OP_WB4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_read(logic [OP_W-1:0] c);
    return (c == OP_RREG) || (c == OP_RD1) || (c == OP_RD2);
  endfunction
endpackage

// File: rtl/hbus_cmd_decode.sv
`timescale 1ns/1ps
module hbus_cmd_decode
  import hbus_front_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   wr_stb_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign idx_o   = addr_i[ADDR_W-1:2];
  assign hit_o   = aligned && (int'(idx_o) < NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_stb
    assign wr_stb_o[g] = sel_i & wr_i & hit_o & (idx_o == IDX_W'(g));
  end
endmodule

// File: rtl/hbus_cmd_seq.sv
`timescale 1ns/1ps
module hbus_cmd_seq
  import hbus_front_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_we_i,
  input  logic [OP_W-1:0] code_i,
  input  logic            sts_we_i,
  input  logic            sts_clr_i,
  input  logic            done_i,
  input  logic [DW-1:0]   eng_rdata_i,
  output logic            busy_o,
  output logic [OP_W-1:0] op_o,
  output logic            start_o,
  output logic            sts_o,
  output logic [DW-1:0]   rdata_o
);
  logic launch, finish;
  assign launch = cmd_we_i && !busy_o && op_is_valid(code_i);
  assign finish = done_i && busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      op_o    <= '0;
      start_o <= 1'b0;
      sts_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      start_o <= launch;
      if (sts_we_i && sts_clr_i) sts_o <= 1'b0;
      if (launch) begin
        busy_o <= 1'b1;
        op_o   <= code_i;
        sts_o  <= 1'b0;
      end
      // completion and launch are exclusive: one needs busy, the other idle
      if (finish) begin
        busy_o <= 1'b0;
        sts_o  <= 1'b1;
        if (op_is_read(op_o)) rdata_o <= eng_rdata_i;
      end
    end
  end
endmodule

// File: rtl/hbus_reg_bank.sv
`timescale 1ns/1ps
module hbus_reg_bank
  import hbus_front_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NREG-1:0]  wr_stb_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [OP_W-1:0]  cmd_view_i,
  input  logic [DW-1:0]    rdata_cap_i,
  input  logic             sts_i,
  output logic [DW-1:0]    cfg_o,
  output logic [DW-1:0]    addr_o,
  output logic [DW-1:0]    wdat_o,
  output logic             ien_o,
  output logic [DW-1:0]    rd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      addr_o <= '0;
      wdat_o <= '0;
      ien_o  <= 1'b0;
    end else begin
      if (wr_stb_i[IDX_CFG]) cfg_o  <= wdata_i;
      if (wr_stb_i[IDX_ADR]) addr_o <= wdata_i;
      if (wr_stb_i[IDX_WDT]) wdat_o <= wdata_i;
      if (wr_stb_i[IDX_IEN]) ien_o  <= wdata_i[0];
    end
  end

  always_comb begin
    rd_o = '0;
    if (hit_i) begin
      case (int'(idx_i))
        IDX_CMD: rd_o = DW'(cmd_view_i);
        IDX_CFG: rd_o = cfg_o;
        IDX_ADR: rd_o = addr_o;
        IDX_WDT: rd_o = wdat_o;
        IDX_RDT: rd_o = rdata_cap_i;
        IDX_IEN: rd_o = DW'(ien_o);
        IDX_STS: rd_o = DW'(sts_i);
        default: rd_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/hbus_cmd_front.sv
`timescale 1ns/1ps
module hbus_cmd_front
  import hbus_front_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DW = 32,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              eng_start_o,
  output logic [OP_W-1:0]   eng_op_o,
  output logic [DW-1:0]     eng_addr_o,
  output logic [DW-1:0]     eng_wdata_o,
  output logic [DW-1:0]     eng_cfg_o,
  input  logic              eng_done_i,
  input  logic [DW-1:0]     eng_rdata_i,
  output logic              irq_o
);
  logic [NREG-1:0]  wr_stb;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             busy_w, sts_w, ien_w;
  logic [OP_W-1:0]  op_w, cmd_view;
  logic [DW-1:0]    rcap_w;

  hbus_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel_i(bus_sel_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wr_stb_o(wr_stb), .hit_o(hit), .idx_o(idx)
  );

  hbus_cmd_seq #(.DW(DW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_we_i(wr_stb[IDX_CMD]), .code_i(bus_wdata_i[OP_W-1:0]),
    .sts_we_i(wr_stb[IDX_STS]), .sts_clr_i(bus_wdata_i[0]),
    .done_i(eng_done_i), .eng_rdata_i(eng_rdata_i),
    .busy_o(busy_w), .op_o(op_w), .start_o(eng_start_o),
    .sts_o(sts_w), .rdata_o(rcap_w)
  );

  assign cmd_view = busy_w ? op_w : '0;

  hbus_reg_bank #(.DW(DW), .IDX_W(IDX_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_stb_i(wr_stb), .wdata_i(bus_wdata_i),
    .hit_i(hit), .idx_i(idx), .cmd_view_i(cmd_view), .rdata_cap_i(rcap_w),
    .sts_i(sts_w), .cfg_o(eng_cfg_o), .addr_o(eng_addr_o), .wdat_o(eng_wdata_o),
    .ien_o(ien_w), .rd_o(bus_rdata_o)
  );

  assign eng_op_o = op_w;
  assign irq_o    = sts_w & ien_w;
endmodule

// File: rtl/hbus_cmd_front_chk.sv
`timescale 1ns/1ps
module hbus_cmd_front_chk
  import hbus_front_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [OP_W-1:0]   code_i,
  input logic              eng_start_o,
  input logic [OP_W-1:0]   eng_op_o,
  input logic              eng_done_i,
  input logic              irq_o,
  input logic              busy_i
);
  logic cmd_wr;
  assign cmd_wr = bus_sel_i && bus_wr_i && (bus_addr_i == '0);

  assert_start_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);
  assert_start_launch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy_i && op_is_valid(code_i)) |=> (eng_start_o && busy_i && eng_op_o == $past(code_i)));
  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && eng_done_i) |=> !busy_i);
  assert_reserved_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy_i && !op_is_valid(code_i)) |=> (!eng_start_o && !busy_i));
  assert_busy_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && busy_i && !eng_done_i) |=> (!eng_start_o && busy_i && eng_op_o == $past(eng_op_o)));
  assert_irq_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_i);
  assert_stray_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && eng_done_i && !cmd_wr) |=> !busy_i);
endmodule

bind hbus_cmd_front hbus_cmd_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
  .bus_addr_i(bus_addr_i), .code_i(bus_wdata_i[3:0]), .eng_start_o(eng_start_o),
  .eng_op_o(eng_op_o), .eng_done_i(eng_done_i), .irq_o(irq_o), .busy_i(busy_w)
);

// File: tb/hbus_cmd_front_tb.sv
`timescale 1ns/1ps
module hbus_cmd_front_tb;
  localparam int AW = 5;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic bus_sel_i = 0, bus_wr_i = 0, eng_done_i = 0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0, eng_rdata_i = '0;
  logic [31:0] bus_rdata_o, eng_addr_o, eng_wdata_o, eng_cfg_o;
  logic [3:0] eng_op_o;
  logic eng_start_o, irq_o;
  int checks = 0, bad = 0;

  always #4 clk_i = ~clk_i;

  hbus_cmd_front u_dut (
    .clk_i, .rst_ni, .bus_sel_i, .bus_wr_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .eng_start_o, .eng_op_o, .eng_addr_o, .eng_wdata_o, .eng_cfg_o,
    .eng_done_i, .eng_rdata_i, .irq_o
  );

  // reference model
  bit m_busy, m_start, m_sts, m_en;
  logic [3:0] m_op;
  logic [31:0] m_cfg, m_addr, m_wdat, m_rdata;

  function automatic bit valid_code(logic [3:0] c);
    return c inside {4'd1, 4'd2, 4'd5, 4'd7, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15};
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_start = 0; m_sts = 0; m_en = 0; m_op = 0;
      m_cfg = 0; m_addr = 0; m_wdat = 0; m_rdata = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      m_start = 0;
      if (bus_sel_i && bus_wr_i && bus_addr_i[1:0] == 2'b00) begin
        case (bus_addr_i[4:2])
          3'd0: if (!was_busy && valid_code(bus_wdata_i[3:0])) begin
                  m_busy = 1; m_op = bus_wdata_i[3:0]; m_start = 1; m_sts = 0;
                end
          3'd1: m_cfg = bus_wdata_i;
          3'd2: m_addr = bus_wdata_i;
          3'd3: m_wdat = bus_wdata_i;
          3'd5: m_en = bus_wdata_i[0];
          3'd6: if (bus_wdata_i[0]) m_sts = 0;
          default: ;
        endcase
      end
      if (eng_done_i && was_busy) begin
        m_busy = 0; m_sts = 1;
        if (m_op == 4'd2 || m_op == 4'd8 || m_op == 4'd9) m_rdata = eng_rdata_i;
      end
    end
  end

  function automatic logic [31:0] mread(logic [AW-1:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return m_busy ? {28'h0, m_op} : 32'h0;
      3'd1: return m_cfg;
      3'd2: return m_addr;
      3'd3: return m_wdat;
      3'd4: return m_rdata;
      3'd5: return {31'h0, m_en};
      3'd6: return {31'h0, m_sts};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of registered outputs
  always @(negedge clk_i) if (rst_ni) begin
    chk("R3 start", {31'h0, eng_start_o}, {31'h0, m_start});
    if (m_start) begin
      chk("R3 op", {28'h0, eng_op_o}, {28'h0, m_op});
      chk("R3 addr", eng_addr_o, m_addr);
      chk("R3 wdata", eng_wdata_o, m_wdat);
    end
    chk("R8 irq", {31'h0, irq_o}, {31'h0, m_sts & m_en});
    chk("R11 cfg", eng_cfg_o, m_cfg);
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk_i); bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i); bus_sel_i = 0; bus_wr_i = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, string req);
    @(negedge clk_i); bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = a;
    #1 chk(req, bus_rdata_o, mread(a));
  endtask

  task automatic done(logic [31:0] d);
    @(negedge clk_i); eng_done_i = 1; eng_rdata_i = d;
    @(negedge clk_i); eng_done_i = 0;
  endtask

  task automatic wr_done(logic [AW-1:0] a, logic [31:0] w, logic [31:0] d);
    @(negedge clk_i); bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = w;
    eng_done_i = 1; eng_rdata_i = d;
    @(negedge clk_i); bus_sel_i = 0; bus_wr_i = 0; eng_done_i = 0;
  endtask

  initial begin
    #20; @(negedge clk_i); rst_ni = 1;
    #1 chk("R1 start", {31'h0, eng_start_o}, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    for (int i = 0; i < 8; i++) rd(AW'(i * 4), "R1 reset read");

    wr(5'h04, 32'hA5C3_0F12); wr(5'h08, 32'h01FF_FFFE);
    wr(5'h0C, 32'h1234_5678); wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h04, "R2 cfg"); rd(5'h08, "R2 addr"); rd(5'h0C, "R2 wdata"); rd(5'h14, "R2 ien");
    wr(5'h10, 32'hDEAD_0000); rd(5'h10, "R2 rdata ro");
    wr(5'h1C, 32'h5555_5555); rd(5'h1C, "R2 unmapped");
    wr(5'h05, 32'h0000_0000); rd(5'h04, "R2 misaligned write"); rd(5'h05, "R2 misaligned read");

    // write 4 bytes
    wr(5'h00, 32'h0000_000F); rd(5'h00, "R4 busy view");
    wr(5'h00, 32'h0000_0001); rd(5'h00, "R6 busy ignore");
    rd(5'h18, "R7 cleared at launch");
    done(32'hCAFE_F00D);
    rd(5'h00, "R4 idle after done"); rd(5'h10, "R9 write op no capture");
    rd(5'h18, "R7 set on done");
    wr(5'h18, 32'h0); rd(5'h18, "R7 write 0 no effect");
    wr(5'h18, 32'h1); rd(5'h18, "R7 w1c");

    // reserved codes
    wr(5'h00, 32'h0000_0003); rd(5'h00, "R5 reserved 0011");
    wr(5'h00, 32'h0000_000A); rd(5'h00, "R5 reserved 1010");

    // stray done
    done(32'h1111_2222);
    rd(5'h00, "R10 cmd"); rd(5'h18, "R10 sts"); rd(5'h10, "R10 rdata");

    // two-word read
    wr(5'h08, 32'h0000_0100);
    wr(5'h00, 32'h0000_0009); done(32'hDEAD_BEEF);
    rd(5'h10, "R9 two-word capture");

    // register read, clearing write during completion
    wr(5'h08, 32'h0000_1000);
    wr(5'h00, 32'h0000_0002);
    wr_done(5'h18, 32'h1, 32'h0000_8F1F);
    rd(5'h18, "R7 set wins"); rd(5'h10, "R9 reg read capture");
    wr(5'h14, 32'h0); rd(5'h14, "R8 enable off");

    // one-word read with done in the start cycle
    @(negedge clk_i); bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = 5'h00; bus_wdata_i = 32'h8;
    @(negedge clk_i); bus_sel_i = 0; bus_wr_i = 0; eng_done_i = 1; eng_rdata_i = 32'h0000_ABCD;
    @(negedge clk_i); eng_done_i = 0;
    rd(5'h00, "R4 quick done"); rd(5'h10, "R9 one-word capture");

    // wake, reset, register write
    wr(5'h00, 32'h5); done(32'h0); rd(5'h10, "R9 wake no capture");
    wr(5'h00, 32'h1); done(32'h0);
    wr(5'h0C, 32'h0000_00C0); wr(5'h00, 32'h7); rd(5'h00, "R4 reg write busy"); done(32'h0);
    rd(5'h00, "R4 final idle");

    repeat (3) @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    checks++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule